// File: doc/BRIEF.md
# Hyperdimensional Trigram Text Encoder

This block reads a text one character code at a time and folds it into a single binary hypervector of `DIM` bits. Each of 27 symbols (26 letters and a space) owns a fixed pseudo-random hypervector. These vectors are held in an on-block item store, which fills itself after reset. Every run of three consecutive symbols forms a trigram vector: the oldest symbol's vector is rotated by two bits, the middle one is rotated by one bit, and the result is combined with the newest one by XOR. Each trigram is added into one saturating counter per bit. When the end-of-text strobe arrives, the counters are thresholded by majority into the output vector.

Work on the counters and the output register is done `CHUNK` bits per cycle. A trigram therefore costs `DIM/CHUNK` cycles. The final thresholding costs the same. A controller sequences this work with five states:

- **INIT**: the item store is filled.
- **COLLECT**: symbols are accepted.
- **ACCUM**: one trigram is added, chunk by chunk.
- **THRESH**: the counters are turned into output bits and cleared, chunk by chunk.
- **DONE**: a one-cycle completion pulse.

The transitions are:

- INIT→COLLECT when the store is full.
- COLLECT→ACCUM when a symbol is accepted and at least two symbols are already held.
- COLLECT→THRESH on end-of-text.
- ACCUM→COLLECT after the last chunk.
- THRESH→DONE after the last chunk.
- DONE→COLLECT unconditionally, with the symbol and trigram counts cleared.

Top module: `hdc_trigram_encoder`

## Requirements
- R1: After reset the block is in INIT with `sym_ready`, `vec_done`, `short_err` and every bit of `vec_out` at 0. `sym_ready` first rises once the item store holds all 27 vectors.
- R2: Codes 0 to 25 stand for the letters A to Z and code 26 for the space. Codes 27 to 31 are treated exactly as code 26.
- R3: The item store is filled from a 32-bit xorshift generator (x^=x<<13, x^=x>>17, x^=x<<5) started at `SEED`. Successive outputs fill 32-bit words in order: symbol 0 word 0 (bits 31:0), then symbol 0 word 1, and so on through symbol 26.
- R4: A trigram vector is rotl2(old) XOR rotl1(mid) XOR new. Here rotl1(v) moves bit i to bit i+1 and bit DIM-1 to bit 0.
- R5: A text of n symbols gives n-2 trigrams, so nothing is added before the third symbol. After any symbol that completes a trigram, `sym_ready` is 0 on the next cycle for DIM/CHUNK cycles.
- R6: The trigram count and the per-bit counters saturate at 2^CW-1. An output bit is 1 when twice its count exceeds the trigram count. On equality the bit is taken from the space symbol's vector.
- R7: A text of fewer than three symbols yields an all-zero `vec_out` with `short_err` at 1. `short_err` is re-evaluated at every end-of-text.
- R8: `vec_done` is a single-cycle pulse one cycle after the last chunk is thresholded. The following text starts from empty counters.
- R9: While `eot` is high, `sym_ready` is 0, so a symbol offered in that cycle is not taken into the text.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_valid | input | 1 | A symbol code is offered |
| sym_code | input | 5 | Symbol code (see R2) |
| sym_ready | output | 1 | The block takes the offered symbol at this edge |
| eot | input | 1 | End-of-text strobe, sampled in COLLECT |
| vec_out | output | DIM | Text hypervector, valid while `vec_done` is high and held afterwards |
| vec_done | output | 1 | One-cycle completion pulse |
| short_err | output | 1 | The last text had fewer than three symbols |

## Verification
The assertions assume that `eot` is raised only while the block is in COLLECT with `sym_ready` otherwise high. A strobe raised during INIT, ACCUM or THRESH would be lost, and the completion checks would then have nothing to follow. They also assume that `SEED` is nonzero, so the generator never stalls. The stimulus polls `sym_ready` with `eot` low before every symbol and before every end-of-text. It changes inputs only on falling edges. It deliberately raises `eot` together with `sym_valid` once, to show that the symbol is dropped.

// File: rtl/hdc_pkg.sv
package hdc_pkg;

    localparam int NSYM       = 27;
    localparam int SYM_W      = 5;
    localparam int SPACE_CODE = 26;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_COLLECT,
        ST_ACCUM,
        ST_THRESH,
        ST_DONE
    } enc_state_t;

    function automatic logic [31:0] xs32_step(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic logic [SYM_W-1:0] fold_code(input logic [SYM_W-1:0] c);
        return (c > SYM_W'(SPACE_CODE)) ? SYM_W'(SPACE_CODE) : c;
    endfunction

endpackage

// File: rtl/hdc_item_mem.sv
module hdc_item_mem
    import hdc_pkg::*;
#(
    parameter int          DIM  = 256,
    parameter logic [31:0] SEED = 32'h1F2E_3D4C
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             filled,
    input  logic [SYM_W-1:0] code_old,
    input  logic [SYM_W-1:0] code_mid,
    input  logic [SYM_W-1:0] code_new,
    output logic [DIM-1:0]   vec_old,
    output logic [DIM-1:0]   vec_mid,
    output logic [DIM-1:0]   vec_new,
    output logic [DIM-1:0]   vec_tie
);

    localparam int NW = DIM / 32;
    localparam int WW = (NW > 1) ? $clog2(NW) : 1;

    logic [DIM-1:0]   store [NSYM];
    logic [31:0]      prng_q;
    logic [31:0]      prng_nxt;
    logic [SYM_W-1:0] fsym_q;
    logic [WW-1:0]    fword_q;
    logic             busy_q;

    assign prng_nxt = xs32_step(prng_q);
    assign filled   = !busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prng_q  <= SEED;
            fsym_q  <= '0;
            fword_q <= '0;
            busy_q  <= 1'b1;
        end else if (busy_q) begin
            prng_q <= prng_nxt;
            if (fword_q == WW'(NW - 1)) begin
                fword_q <= '0;
                if (fsym_q == SYM_W'(NSYM - 1)) begin
                    busy_q <= 1'b0;
                end else begin
                    fsym_q <= fsym_q + 1'b1;
                end
            end else begin
                fword_q <= fword_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < NSYM; s++) begin
            for (int w = 0; w < NW; w++) begin
                if (busy_q && fsym_q == SYM_W'(s) && fword_q == WW'(w)) begin
                    store[s][w*32 +: 32] <= prng_nxt;
                end
            end
        end
    end

    assign vec_old = store[code_old];
    assign vec_mid = store[code_mid];
    assign vec_new = store[code_new];
    assign vec_tie = store[SPACE_CODE];

    // R3: once the store is full it is never refilled
    a_r3_fill_once: assert property (@(posedge clk) disable iff (!rst_n)
        filled |=> filled);

endmodule

// File: rtl/hdc_bind.sv
module hdc_bind #(
    parameter int DIM = 256
) (
    input  logic [DIM-1:0] v_old,
    input  logic [DIM-1:0] v_mid,
    input  logic [DIM-1:0] v_new,
    output logic [DIM-1:0] v_tri
);

    logic [DIM-1:0] old_rot2;
    logic [DIM-1:0] mid_rot1;

    assign old_rot2 = {v_old[DIM-3:0], v_old[DIM-1:DIM-2]};
    assign mid_rot1 = {v_mid[DIM-2:0], v_mid[DIM-1]};
    assign v_tri    = old_rot2 ^ mid_rot1 ^ v_new;

endmodule

// File: rtl/hdc_bundle.sv
module hdc_bundle #(
    parameter int DIM   = 256,
    parameter int CHUNK = 64,
    parameter int CW    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            add_en,
    input  logic            thr_en,
    input  logic            zero_en,
    input  logic [(((DIM/CHUNK) > 1) ? $clog2(DIM/CHUNK) : 1)-1:0] chunk_sel,
    input  logic [DIM-1:0]  tri_vec,
    input  logic [DIM-1:0]  tie_vec,
    input  logic [CW-1:0]   ntri,
    output logic [DIM-1:0]  vec_o
);

    localparam int NCHUNK = DIM / CHUNK;
    localparam int CIW    = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;

    for (genvar b = 0; b < DIM; b++) begin : g_bit
        localparam int CI = b / CHUNK;
        logic          hit;
        logic [CW-1:0] cnt_q;
        logic          bit_q;
        logic [CW:0]   twice;
        logic [CW:0]   ref_n;

        assign hit   = (chunk_sel == CIW'(CI));
        assign twice = {cnt_q, 1'b0};
        assign ref_n = {1'b0, ntri};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
                bit_q <= 1'b0;
            end else if (thr_en && hit) begin
                cnt_q <= '0;
                if (zero_en) begin
                    bit_q <= 1'b0;
                end else if (twice > ref_n) begin
                    bit_q <= 1'b1;
                end else if (twice == ref_n) begin
                    bit_q <= tie_vec[b];
                end else begin
                    bit_q <= 1'b0;
                end
            end else if (add_en && hit && tri_vec[b] && (cnt_q != '1)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end

        assign vec_o[b] = bit_q;

        // R6: a counter never wraps from its ceiling back to zero while adding
        a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (add_en && (cnt_q == '1)) |=> (cnt_q == '1));
    end

endmodule

// File: rtl/hdc_trigram_encoder.sv
module hdc_trigram_encoder
    import hdc_pkg::*;
#(
    parameter int          DIM   = 256,
    parameter int          CHUNK = 64,
    parameter int          CW    = 8,
    parameter logic [31:0] SEED  = 32'h1F2E_3D4C
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sym_valid,
    input  logic [4:0]     sym_code,
    output logic           sym_ready,
    input  logic           eot,
    output logic [DIM-1:0] vec_out,
    output logic           vec_done,
    output logic           short_err
);

    localparam int NCHUNK = DIM / CHUNK;
    localparam int CIW    = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;

    enc_state_t       state_q, state_d;
    logic [SYM_W-1:0] h_old_q, h_mid_q, h_new_q;
    logic [1:0]       nsym_q;
    logic [CW-1:0]    ntri_q;
    logic [CIW-1:0]   chk_q;
    logic             err_q;
    logic             last_chunk;
    logic             accept;
    logic             add_en, thr_en;
    logic             store_full;
    logic [DIM-1:0]   v_old, v_mid, v_new, v_tie, v_tri;

    assign last_chunk = (chk_q == CIW'(NCHUNK - 1));
    assign accept     = sym_valid && sym_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:    if (store_full) state_d = ST_COLLECT;
            ST_COLLECT: begin
                if (eot)                             state_d = ST_THRESH;
                else if (accept && nsym_q >= 2'd2)   state_d = ST_ACCUM;
            end
            ST_ACCUM:   if (last_chunk) state_d = ST_COLLECT;
            ST_THRESH:  if (last_chunk) state_d = ST_DONE;
            ST_DONE:    state_d = ST_COLLECT;
            default:    state_d = ST_INIT;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        sym_ready = 1'b0;
        vec_done  = 1'b0;
        add_en    = 1'b0;
        thr_en    = 1'b0;
        unique case (state_q)
            ST_INIT:    ;
            ST_COLLECT: sym_ready = !eot;
            ST_ACCUM:   add_en    = 1'b1;
            ST_THRESH:  thr_en    = 1'b1;
            ST_DONE:    vec_done  = 1'b1;
            default:    ;
        endcase
    end

    // symbol history, counts and chunk pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_old_q <= '0;
            h_mid_q <= '0;
            h_new_q <= '0;
            nsym_q  <= '0;
            ntri_q  <= '0;
            chk_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            if (accept) begin
                h_old_q <= h_mid_q;
                h_mid_q <= h_new_q;
                h_new_q <= fold_code(sym_code);
                if (nsym_q != 2'd3) nsym_q <= nsym_q + 1'b1;
            end
            if (add_en || thr_en) begin
                chk_q <= last_chunk ? '0 : chk_q + 1'b1;
            end else begin
                chk_q <= '0;
            end
            if (add_en && last_chunk && (ntri_q != '1)) begin
                ntri_q <= ntri_q + 1'b1;
            end
            if (state_q == ST_COLLECT && eot) begin
                err_q <= (nsym_q != 2'd3);
            end
            if (vec_done) begin
                nsym_q <= '0;
                ntri_q <= '0;
            end
        end
    end

    assign short_err = err_q;

    hdc_item_mem #(.DIM(DIM), .SEED(SEED)) u_items (
        .clk      (clk),
        .rst_n    (rst_n),
        .filled   (store_full),
        .code_old (h_old_q),
        .code_mid (h_mid_q),
        .code_new (h_new_q),
        .vec_old  (v_old),
        .vec_mid  (v_mid),
        .vec_new  (v_new),
        .vec_tie  (v_tie)
    );

    hdc_bind #(.DIM(DIM)) u_bind (
        .v_old (v_old),
        .v_mid (v_mid),
        .v_new (v_new),
        .v_tri (v_tri)
    );

    hdc_bundle #(.DIM(DIM), .CHUNK(CHUNK), .CW(CW)) u_bundle (
        .clk       (clk),
        .rst_n     (rst_n),
        .add_en    (add_en),
        .thr_en    (thr_en),
        .zero_en   (err_q),
        .chunk_sel (chk_q),
        .tri_vec   (v_tri),
        .tie_vec   (v_tie),
        .ntri      (ntri_q),
        .vec_o     (vec_out)
    );

    // R1: nothing is offered or completed while the store fills
    a_r1_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !store_full |-> (!sym_ready && !vec_done));

    // R5: a symbol completing a trigram closes the input on the next cycle
    a_r5_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && nsym_q >= 2'd2) |=> !sym_ready);

    // R7: a short text reports an all-zero vector
    a_r7_short_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_done && short_err) |-> (vec_out == '0));

    // R8: completion is a single-cycle pulse that follows thresholding
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vec_done |=> !vec_done);

    a_r8_done_after_thresh: assert property (@(posedge clk) disable iff (!rst_n)
        vec_done |-> ($past(state_q) == ST_THRESH));

endmodule

// File: tb/hdc_trigram_encoder_tb.sv
module hdc_trigram_encoder_tb;

    localparam int          DIM   = 256;
    localparam int          CHUNK = 64;
    localparam int          CW    = 8;
    localparam logic [31:0] SEED  = 32'h1F2E_3D4C;
    localparam int          NV    = 7;

    // stimulus table: symbol i sits at bits [5i+4:5i]
    localparam int          T_LEN [NV] = '{7, 3, 2, 4, 0, 12, 3};
    localparam logic [59:0] T_TXT [NV] = '{
        {25'd0, 5'd13, 5'd8, 5'd1, 5'd26, 5'd7, 5'd2, 5'd8},
        {45'd0, 5'd0, 5'd0, 5'd0},
        {50'd0, 5'd1, 5'd0},
        {40'd0, 5'd3, 5'd2, 5'd1, 5'd0},
        60'd0,
        {5'd14, 5'd5, 5'd26, 5'd10, 5'd2, 5'd8, 5'd20, 5'd16, 5'd26, 5'd4, 5'd7, 5'd19},
        {45'd0, 5'd1, 5'd30, 5'd0}
    };
    localparam logic        T_ERR [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sym_valid = 1'b0;
    logic [4:0]     sym_code = '0;
    logic           eot = 1'b0;
    logic           sym_ready;
    logic [DIM-1:0] vec_out;
    logic           vec_done;
    logic           short_err;

    int total = 0;
    int bad   = 0;
    logic [DIM-1:0] imem [27];

    always #4 clk = ~clk;

    hdc_trigram_encoder #(.DIM(DIM), .CHUNK(CHUNK), .CW(CW), .SEED(SEED)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sym_code  (sym_code),
        .sym_ready (sym_ready),
        .eot       (eot),
        .vec_out   (vec_out),
        .vec_done  (vec_done),
        .short_err (short_err)
    );

    function automatic logic [31:0] xs(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic logic [DIM-1:0] rotl(input logic [DIM-1:0] v);
        return {v[DIM-2:0], v[DIM-1]};
    endfunction

    function automatic int fold(input logic [4:0] c);
        return (c > 5'd26) ? 26 : int'(c);
    endfunction

    function automatic logic [DIM-1:0] model(input int n, input logic [59:0] t);
        int cnt [DIM];
        logic [DIM-1:0] tv;
        logic [DIM-1:0] r;
        int ntri;
        for (int b = 0; b < DIM; b++) cnt[b] = 0;
        for (int k = 2; k < n; k++) begin
            tv = rotl(rotl(imem[fold(t[5*(k-2) +: 5])]))
               ^ rotl(imem[fold(t[5*(k-1) +: 5])])
               ^ imem[fold(t[5*k +: 5])];
            for (int b = 0; b < DIM; b++)
                if (tv[b] && cnt[b] < 255) cnt[b]++;
        end
        r = '0;
        ntri = (n < 3) ? 0 : n - 2;
        if (n >= 3) begin
            for (int b = 0; b < DIM; b++) begin
                if (2 * cnt[b] > ntri)       r[b] = 1'b1;
                else if (2 * cnt[b] == ntri) r[b] = imem[26][b];
            end
        end
        return r;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic check_vec(input string req, input logic [DIM-1:0] act, input logic [DIM-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [4:0] c);
        @(negedge clk);
        while (!sym_ready) @(negedge clk);
        sym_valid = 1'b1;
        sym_code  = c;
        @(negedge clk);
        sym_valid = 1'b0;
    endtask

    task automatic finish_text();
        @(negedge clk);
        while (!sym_ready) @(negedge clk);
        eot = 1'b1;
        @(negedge clk);
        eot = 1'b0;
        while (!vec_done) @(negedge clk);
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
    end

    initial begin
        logic [31:0] st;
        st = SEED;
        for (int s = 0; s < 27; s++)
            for (int w = 0; w < DIM / 32; w++) begin
                st = xs(st);
                imem[s][w*32 +: 32] = st;
            end

        repeat (3) @(negedge clk);
        // R1: reset state
        check_bit("R1 ready low in init", sym_ready, 1'b0);
        check_bit("R1 done low", vec_done, 1'b0);
        check_bit("R1 err low", short_err, 1'b0);
        check_vec("R1 vec zero", vec_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 ready still low while filling", sym_ready, 1'b0);

        // table walk: R2 R3 R4 R6 R7 R8 (each text starts clean)
        for (int i = 0; i < NV; i++) begin
            for (int k = 0; k < T_LEN[i]; k++) send(T_TXT[i][5*k +: 5]);
            finish_text();
            check_vec($sformatf("R4 R6 R7 R8 vector, entry %0d", i), vec_out, model(T_LEN[i], T_TXT[i]));
            check_bit($sformatf("R7 error flag, entry %0d", i), short_err, T_ERR[i]);
        end

        // R2: code 30 behaves as space
        check_vec("R2 folded code equals space", vec_out,
                  model(3, {45'd0, 5'd1, 5'd26, 5'd0}));

        // R5: no trigram before the third symbol, then input closes
        send(5'd0);
        check_bit("R5 ready after first symbol", sym_ready, 1'b1);
        send(5'd0);
        check_bit("R5 ready after second symbol", sym_ready, 1'b1);
        send(5'd0);
        check_bit("R5 ready low while adding", sym_ready, 1'b0);

        // R9: symbol offered with eot is dropped
        @(negedge clk);
        while (!sym_ready) @(negedge clk);
        sym_valid = 1'b1;
        sym_code  = 5'd1;
        eot       = 1'b1;
        #1;
        check_bit("R9 ready low under eot", sym_ready, 1'b0);
        @(negedge clk);
        sym_valid = 1'b0;
        eot       = 1'b0;
        while (!vec_done) @(negedge clk);
        check_vec("R9 dropped symbol has no effect", vec_out, model(3, 60'd0));
        check_bit("R9 no error", short_err, 1'b0);
        @(negedge clk);
        // R8: done lasts one cycle
        check_bit("R8 done single pulse", vec_done, 1'b0);

        report();
    end

endmodule